// File: doc/BRIEF.md
# Card Host Interrupt and DMA Request Router

This block collects the event flags of a memory-card host controller into a 13-bit request register and gates them through a 13-bit mask. From these it drives one interrupt line to the CPU and two DMA request lines, one for receive and one for transmit.

The data path and the command sequencer raise and drop individual flags through per-bit set and clear strobes. Software writes the mask through a simple write port and reads it back. Clock start and stop pulses maintain a clock-enabled status and the clock-off flag.

When the controller runs in DMA mode, the receive and transmit FIFO service flags no longer reach the CPU interrupt. They drive the DMA request lines instead. All outputs are registered and follow the state produced at the same clock edge.

Top module: `card_irq_router`

## Requirements
- R1: After reset (rst_ni low) the request register, the mask, clk_en_o, irq_o, rx_dma_o and tx_dma_o are all zero.
- R2: A mask write (mask_we_i high) stores only bits 12:0 of mask_wdata_i. The stored value is visible on mask_rdata_o after the same clock edge.
- R3: A request bit is set by req_set_i and cleared by req_clr_i at the next edge. When both strobes hit the same bit in one cycle, the set takes effect.
- R4: With DMA mode off, irq_o is high after an edge exactly when some request bit is 1 and its mask bit is 0. A mask bit of 1 hides that request.
- R5: With dma_en_i high, request bits 5 (receive FIFO) and 6 (transmit FIFO) are treated as masked for irq_o, whatever the mask holds.
- R6: rx_dma_o equals request bit 5 and tx_dma_o equals request bit 6 while dma_en_i was high at the last edge. Both are 0 while it was low.
- R7: A clock start pulse (clk_start_i) without a stop pulse sets clk_en_o and clears request bit 4 (clock off). This overrides a set strobe on bit 4 in the same cycle.
- R8: A clock stop pulse (clk_stop_i) clears clk_en_o and sets request bit 4. It wins over a start pulse or a clear strobe in the same cycle.
- R9: A change of dma_en_i alone re-evaluates irq_o, rx_dma_o and tx_dma_o at the next edge. The request register and the mask are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mask_we_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 32 | Mask write data, bits 12:0 used |
| mask_rdata_o | output | 13 | Current mask |
| req_set_i | input | 13 | Per-bit request set strobes |
| req_clr_i | input | 13 | Per-bit request clear strobes |
| dma_en_i | input | 1 | DMA mode enable level |
| clk_start_i | input | 1 | Clock start pulse |
| clk_stop_i | input | 1 | Clock stop pulse |
| req_o | output | 13 | Current request register |
| clk_en_o | output | 1 | Clock-enabled status |
| irq_o | output | 1 | CPU interrupt |
| rx_dma_o | output | 1 | Receive DMA request |
| tx_dma_o | output | 1 | Transmit DMA request |

## Verification
A corrupted request or mask bit shows on req_o or mask_rdata_o after the very edge that should have produced it. A wrong gating term shows on irq_o or the DMA lines in the same sample. The bench sweeps every request bit against both mask polarities and both DMA modes. It then runs a long pseudo-random strobe stream against an arithmetic reference. Any divergence is caught one cycle after the faulty edge, before later strobes can mask it.

// File: rtl/card_irq_pkg.sv
package card_irq_pkg;
  localparam int unsigned SRC_W      = 13;
  localparam int unsigned BUS_W      = 32;
  localparam int unsigned CLKOFF_BIT = 4;
  localparam int unsigned RXREQ_BIT  = 5;
  localparam int unsigned TXREQ_BIT  = 6;
endpackage

// File: rtl/cirq_req_bank.sv
module cirq_req_bank #(
  parameter int unsigned N          = 13,
  parameter int unsigned CLKOFF_BIT = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         start_i,
  input  logic         stop_i,
  output logic [N-1:0] req_o,
  output logic [N-1:0] req_nxt_o,
  output logic         clk_en_o
);
  logic [N-1:0] req_q, req_d;
  logic         clk_en_q, clk_en_d;

  always_comb begin
    req_d    = (req_q & ~clr_i) | set_i;
    clk_en_d = clk_en_q;
    if (stop_i) begin
      req_d[CLKOFF_BIT] = 1'b1;
      clk_en_d          = 1'b0;
    end else if (start_i) begin
      req_d[CLKOFF_BIT] = 1'b0;
      clk_en_d          = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= '0;
      clk_en_q <= 1'b0;
    end else begin
      req_q    <= req_d;
      clk_en_q <= clk_en_d;
    end
  end

  assign req_o     = req_q;
  assign req_nxt_o = req_d;
  assign clk_en_o  = clk_en_q;
endmodule

// File: rtl/cirq_mask_reg.sv
module cirq_mask_reg #(
  parameter int unsigned N  = 13,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [N-1:0]  mask_o,
  output logic [N-1:0]  mask_nxt_o
);
  logic [N-1:0] mask_q, mask_d;
  logic         unused_hi;

  assign unused_hi = ^wdata_i[DW-1:N];
  assign mask_d    = we_i ? wdata_i[N-1:0] : mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  assign mask_o     = mask_q;
  assign mask_nxt_o = mask_d;
endmodule

// File: rtl/cirq_route.sv
module cirq_route #(
  parameter int unsigned N      = 13,
  parameter int unsigned RX_BIT = 5,
  parameter int unsigned TX_BIT = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] mask_i,
  input  logic         dma_en_i,
  output logic         irq_o,
  output logic         rx_dma_o,
  output logic         tx_dma_o
);
  logic [N-1:0] fifo_sel, eff_mask;

  // bits steered to DMA when DMA mode is on
  for (genvar g = 0; g < N; g++) begin : g_sel
    assign fifo_sel[g] = (g == RX_BIT) || (g == TX_BIT);
  end

  assign eff_mask = mask_i | (dma_en_i ? fifo_sel : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o    <= 1'b0;
      rx_dma_o <= 1'b0;
      tx_dma_o <= 1'b0;
    end else begin
      irq_o    <= |(req_i & ~eff_mask);
      rx_dma_o <= dma_en_i & req_i[RX_BIT];
      tx_dma_o <= dma_en_i & req_i[TX_BIT];
    end
  end
endmodule

// File: rtl/card_irq_router.sv
module card_irq_router
  import card_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = SRC_W,
  parameter int unsigned DATA_W  = BUS_W,
  parameter int unsigned CLK_BIT = CLKOFF_BIT,
  parameter int unsigned RX_BIT  = RXREQ_BIT,
  parameter int unsigned TX_BIT  = TXREQ_BIT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               mask_we_i,
  input  logic [DATA_W-1:0]  mask_wdata_i,
  output logic [NUM_SRC-1:0] mask_rdata_o,
  input  logic [NUM_SRC-1:0] req_set_i,
  input  logic [NUM_SRC-1:0] req_clr_i,
  input  logic               dma_en_i,
  input  logic               clk_start_i,
  input  logic               clk_stop_i,
  output logic [NUM_SRC-1:0] req_o,
  output logic               clk_en_o,
  output logic               irq_o,
  output logic               rx_dma_o,
  output logic               tx_dma_o
);
  logic [NUM_SRC-1:0] req_nxt, mask_nxt;

  cirq_req_bank #(.N(NUM_SRC), .CLKOFF_BIT(CLK_BIT)) i_req (
    .clk_i, .rst_ni,
    .set_i(req_set_i), .clr_i(req_clr_i),
    .start_i(clk_start_i), .stop_i(clk_stop_i),
    .req_o(req_o), .req_nxt_o(req_nxt), .clk_en_o(clk_en_o)
  );

  cirq_mask_reg #(.N(NUM_SRC), .DW(DATA_W)) i_mask (
    .clk_i, .rst_ni,
    .we_i(mask_we_i), .wdata_i(mask_wdata_i),
    .mask_o(mask_rdata_o), .mask_nxt_o(mask_nxt)
  );

  cirq_route #(.N(NUM_SRC), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)) i_route (
    .clk_i, .rst_ni,
    .req_i(req_nxt), .mask_i(mask_nxt), .dma_en_i(dma_en_i),
    .irq_o(irq_o), .rx_dma_o(rx_dma_o), .tx_dma_o(tx_dma_o)
  );
endmodule

// File: rtl/card_irq_router_chk.sv
module card_irq_router_chk #(
  parameter int unsigned NUM_SRC = 13,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CLK_BIT = 4,
  parameter int unsigned RX_BIT  = 5,
  parameter int unsigned TX_BIT  = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               mask_we_i,
  input logic [DATA_W-1:0]  mask_wdata_i,
  input logic [NUM_SRC-1:0] mask_rdata_o,
  input logic [NUM_SRC-1:0] req_set_i,
  input logic [NUM_SRC-1:0] req_clr_i,
  input logic               dma_en_i,
  input logic               clk_start_i,
  input logic               clk_stop_i,
  input logic [NUM_SRC-1:0] req_o,
  input logic               clk_en_o,
  input logic               irq_o,
  input logic               rx_dma_o,
  input logic               tx_dma_o
);
  localparam logic [NUM_SRC-1:0] CLK_M  = NUM_SRC'(1) << CLK_BIT;
  localparam logic [NUM_SRC-1:0] FIFO_M = (NUM_SRC'(1) << RX_BIT) | (NUM_SRC'(1) << TX_BIT);

  logic               dma_q;
  logic [NUM_SRC-1:0] set_m, clr_m;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dma_q <= 1'b0;
    else         dma_q <= dma_en_i;
  end

  assign set_m = req_set_i & ~CLK_M;
  assign clr_m = req_clr_i & ~req_set_i & ~CLK_M;

  AST_MASK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_we_i |=> mask_rdata_o == $past(mask_wdata_i[NUM_SRC-1:0])); // R2
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_m != '0) |=> ((req_o & $past(set_m)) == $past(set_m))); // R3
  AST_CLR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_m != '0) |=> ((req_o & $past(clr_m)) == '0)); // R3
  AST_IRQ_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(req_o & ~(mask_rdata_o | (dma_q ? FIFO_M : '0)))); // R4
  AST_FIFO_HIDDEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_q && ((req_o & ~mask_rdata_o & ~FIFO_M) == '0)) |-> !irq_o); // R5
  AST_RX_DMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dma_o == (dma_q && req_o[RX_BIT])); // R6
  AST_TX_DMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_dma_o == (dma_q && req_o[TX_BIT])); // R6
  AST_CLK_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_start_i && !clk_stop_i) |=> (clk_en_o && !req_o[CLK_BIT])); // R7
  AST_CLK_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_stop_i |=> (!clk_en_o && req_o[CLK_BIT])); // R8
  AST_DMA_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mask_we_i && req_set_i == '0 && req_clr_i == '0 && !clk_start_i && !clk_stop_i)
      |=> ($stable(req_o) && $stable(mask_rdata_o) && $stable(clk_en_o))); // R9
endmodule

bind card_irq_router card_irq_router_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .CLK_BIT(CLK_BIT), .RX_BIT(RX_BIT), .TX_BIT(TX_BIT)
) i_card_irq_router_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mask_we_i(mask_we_i), .mask_wdata_i(mask_wdata_i),
  .mask_rdata_o(mask_rdata_o), .req_set_i(req_set_i), .req_clr_i(req_clr_i),
  .dma_en_i(dma_en_i), .clk_start_i(clk_start_i), .clk_stop_i(clk_stop_i),
  .req_o(req_o), .clk_en_o(clk_en_o), .irq_o(irq_o), .rx_dma_o(rx_dma_o), .tx_dma_o(tx_dma_o)
);

// File: tb/test_card_irq_router.sv
`timescale 1ns/1ps
module test_card_irq_router;
  localparam int N = 13;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mask_we_i = 1'b0;
  logic [31:0]   mask_wdata_i = '0;
  logic [N-1:0]  mask_rdata_o;
  logic [N-1:0]  req_set_i = '0;
  logic [N-1:0]  req_clr_i = '0;
  logic          dma_en_i = 1'b0;
  logic          clk_start_i = 1'b0;
  logic          clk_stop_i = 1'b0;
  logic [N-1:0]  req_o;
  logic          clk_en_o, irq_o, rx_dma_o, tx_dma_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [N-1:0] m_req = '0, m_mask = '0;
  logic         m_dma = 1'b0, m_clk = 1'b0;

  card_irq_router i_card_irq_router (.*);

  always #5 clk_i = ~clk_i;

  function automatic logic [N+3:0] expect_vec();
    logic [N-1:0] eff;
    eff = m_mask | (m_dma ? 13'h0060 : 13'h0);
    return {m_clk, |(m_req & ~eff), m_dma & m_req[5], m_dma & m_req[6], m_req};
  endfunction

  task automatic chk(string tag);
    logic [N+3:0] act, exp_v;
    act   = {clk_en_o, irq_o, rx_dma_o, tx_dma_o, req_o};
    exp_v = expect_vec();
    n_run++;
    if (act !== exp_v || mask_rdata_o !== m_mask) begin
      n_fail++;
      $display("FAIL %s: act {clk,irq,rx,tx,req}=%h mask=%h exp=%h mask=%h",
               tag, act, mask_rdata_o, exp_v, m_mask);
    end
  endtask

  // apply one cycle of stimulus, update reference, check after the edge
  task automatic step(input logic [N-1:0] set, input logic [N-1:0] clr,
                      input logic we, input logic [31:0] wd, input logic dma,
                      input logic start, input logic stop, input string tag);
    @(negedge clk_i);
    req_set_i = set; req_clr_i = clr; mask_we_i = we; mask_wdata_i = wd;
    dma_en_i = dma; clk_start_i = start; clk_stop_i = stop;
    @(posedge clk_i);
    m_req = (m_req & ~clr) | set;
    if (stop) begin m_req[4] = 1'b1; m_clk = 1'b0; end
    else if (start) begin m_req[4] = 1'b0; m_clk = 1'b1; end
    if (we) m_mask = wd[N-1:0];
    m_dma = dma;
    #2;
    chk(tag);
    req_set_i = '0; req_clr_i = '0; mask_we_i = 1'b0;
    clk_start_i = 1'b0; clk_stop_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: act running exp finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(posedge clk_i);
    #2;
    chk("R1 reset");
    @(negedge clk_i); rst_ni = 1'b1;

    step('0, '0, 1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, "R2 wide write");
    step('0, '0, 1'b1, 32'hABCD_0A5A, 1'b0, 1'b0, 1'b0, "R2 pattern");
    step('0, '0, 1'b1, 32'h0, 1'b0, 1'b0, 1'b0, "R2 zero");

    // sweep: every bit x mask polarity x DMA mode
    for (int b = 0; b < N; b++) begin
      for (int mp = 0; mp < 2; mp++) begin
        for (int d = 0; d < 2; d++) begin
          step('0, '0, 1'b1, mp ? (32'h1 << b) : ~(32'h1 << b), d[0], 1'b0, 1'b0, "R2 sweep mask");
          step(N'(1) << b, '0, 1'b0, '0, d[0], 1'b0, 1'b0,
               d ? "R5 R6 sweep set" : "R4 sweep set");
          step('0, N'(1) << b, 1'b0, '0, d[0], 1'b0, 1'b0, "R3 sweep clear");
        end
      end
    end

    step('0, '0, 1'b1, 32'h0, 1'b0, 1'b0, 1'b0, "R2 unmask");
    step('1, '1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R3 set wins");
    step('0, 13'h1FEF, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R3 clear all but bit4");
    step('0, '0, 1'b0, '0, 1'b0, 1'b1, 1'b0, "R7 start");
    step(13'h0010, '0, 1'b0, '0, 1'b0, 1'b1, 1'b0, "R7 start beats set");
    step('0, 13'h0010, 1'b0, '0, 1'b0, 1'b0, 1'b1, "R8 stop beats clear");
    step('0, '0, 1'b0, '0, 1'b0, 1'b1, 1'b1, "R8 stop beats start");
    step(13'h0060, 13'h0010, 1'b0, '0, 1'b0, 1'b1, 1'b0, "R4 fifo irq");
    step('0, '0, 1'b0, '0, 1'b1, 1'b0, 1'b0, "R9 dma on alone");
    step('0, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R9 dma off alone");

    lf = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
      r = lf;
      step(N'(r[12:0] & r[25:13] & {N{r[26]}}), N'(r[25:13] & {N{r[27]}}),
           r[28] & r[29], {r[31:16], r[15:0] ^ r[31:16]}, r[30],
           r[0] & r[31], r[1] & r[31] & r[2], "R4 random");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule